// File: doc/BRIEF.md
# Boundary Scan Test Access Port Controller

This block is the serial test port of a memory device. Driven by the test clock and the mode-select line, it walks the sixteen-state test port sequence. It routes the serial input through one of four scan paths and presents the path's far end on the serial output. The scan paths are a 3-bit instruction register, a single-bit bypass stage, a 32-bit identification word and a 109-cell boundary chain that captures the device's parallel pin values.

A board tester uses the port in three ways. It reads the identification word to confirm which device is fitted. It shortens the scan chain through the bypass stage when other devices on the same chain are under test. It captures a snapshot of the pin levels through the boundary chain. Driving pins from the boundary cells is outside this block, so the boundary chain only captures and shifts.

Top module: `tap_ctrl_top`

## Requirements
- R1: With `rst` high at a rising `tck` edge, the controller enters Test-Logic-Reset, IDCODE becomes the active instruction, and `tdo_oe` is low from the next falling edge.
- R2: From any state, five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset, and IDCODE is then the active instruction.
- R3: The state sequence is the standard sixteen-state test port diagram. From Run-Test/Idle, `tms` values 1,0,0 reach Shift-DR and 1,1,0,0 reach Shift-IR. A scan may leave through Exit1 into Pause, stay there, and return through Exit2 into Shift without losing register contents.
- R4: The instruction register is 3 bits wide and captures 3'b001 in Capture-IR. In Shift-IR it shifts one bit per rising edge, with bit 0 leaving on `tdo` first and `tdi` entering at bit 2.
- R5: Opcode encoding: 3'b000 selects the boundary chain (external-test capture), 3'b001 the identification word, 3'b100 the boundary chain (sample/preload), and 3'b111 the bypass stage. Every other opcode selects the bypass stage.
- R6: The identification word is {3'b000 revision, 17-bit device code (default 17'h0B5A3), 11'b00000110100 vendor code, 1'b1}. It is captured in Capture-DR and shifted out bit 0 first.
- R7: The bypass stage captures 0 in Capture-DR and delays `tdi` by exactly one shift.
- R8: The boundary chain has 109 cells, numbered 0 to 108. Under both boundary opcodes, each cell captures `pin_i[cell]` in Capture-DR. In Shift-DR, cell 0 leaves first and `tdi` enters cell 108.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R10: The active instruction changes only in Update-IR or Test-Logic-Reset. Shifting a new opcode does not change the selected data path before Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, sampled on both `tck` edges |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data into the selected scan path |
| pin_i | input | 109 | Parallel pin levels captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |

## Verification
The bench exits a partial identification scan through Pause-DR and resumes it. A design that dropped or repeated a bit around the pause would return a corrupted word. It checks `tdo` just after a rising edge to catch a design that updates the output on the wrong clock edge, which would show the shifted bit half a cycle early. It loads two unused opcodes and expects one-shift bypass behaviour, so a decoder that let them fall through to the identification or boundary path would show up. It overshifts the boundary chain by eight bits to show that the cell count is exactly 109. It also escapes from inside a Shift-DR scan with five `tms`-high edges to confirm that the forced return reloads IDCODE.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_t;

  function automatic dr_sel_t decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:             return SEL_ID;
      OP_EXTEST, OP_SAMPLE:  return SEL_BSR;
      default:               return SEL_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= S_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/tap_ireg.sv
module tap_ireg
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_active,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh     <= IR_CAPTURE;
      ir_active <= OP_IDCODE;
    end else begin
      case (state)
        S_CAP_IR: ir_sh <= IR_CAPTURE;
        S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        default:  ir_sh <= ir_sh;
      endcase
      if (state == S_TLR)         ir_active <= OP_IDCODE;
      else if (state == S_UPD_IR) ir_active <= ir_sh;
    end
  end

  assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
  import tap_pkg::*;
#(
  parameter int          BSR_LEN = 109,
  parameter int          ID_W    = 32,
  parameter logic [ID_W-1:0] ID_WORD = '0
) (
  input  logic               tck,
  input  logic               rst,
  input  tap_state_t         state,
  input  dr_sel_t            sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins,
  output logic               dr_lsb,
  output logic               byp_q
);

  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;

  logic cap, sh;
  assign cap = (state == S_CAP_DR);
  assign sh  = (state == S_SH_DR);

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_q  <= ID_WORD;
    end else begin
      if (sel == SEL_BYP) begin
        if (cap)     byp_q <= 1'b0;
        else if (sh) byp_q <= tdi;
      end
      if (sel == SEL_ID) begin
        if (cap)     id_q <= ID_WORD;
        else if (sh) id_q <= {tdi, id_q[ID_W-1:1]};
      end
    end
  end

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic shift_in;
    if (i == BSR_LEN - 1) begin : g_top
      assign shift_in = tdi;
    end else begin : g_mid
      assign shift_in = bsr_q[i+1];
    end
    always_ff @(posedge tck) begin
      if (rst)                         bsr_q[i] <= 1'b0;
      else if (sel == SEL_BSR && cap)  bsr_q[i] <= pins[i];
      else if (sel == SEL_BSR && sh)   bsr_q[i] <= shift_in;
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:  dr_lsb = id_q[0];
      SEL_BSR: dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/tap_ctrl_top.sv
module tap_ctrl_top
  import tap_pkg::*;
#(
  parameter int          BSR_LEN     = 109,
  parameter logic [2:0]  REVISION    = 3'b000,
  parameter logic [16:0] DEVICE_CODE = 17'h0B5A3,
  parameter logic [10:0] VENDOR_CODE = 11'b00000110100
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_i,
  output logic               tdo,
  output logic               tdo_oe
);

  localparam int          ID_W    = 32;
  localparam logic [ID_W-1:0] ID_WORD = {REVISION, DEVICE_CODE, VENDOR_CODE, 1'b1};

  tap_state_t      state;
  logic [IR_W-1:0] ir_active;
  logic            ir_lsb, dr_lsb, byp_bit;
  dr_sel_t         sel;

  assign sel = decode_op(ir_active);

  tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

  tap_ireg u_ir (
    .tck(tck), .rst(rst), .state(state), .tdi(tdi),
    .ir_active(ir_active), .ir_lsb(ir_lsb)
  );

  tap_dregs #(.BSR_LEN(BSR_LEN), .ID_W(ID_W), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .rst(rst), .state(state), .sel(sel), .tdi(tdi),
    .pins(pin_i), .dr_lsb(dr_lsb), .byp_q(byp_bit)
  );

  logic shifting;
  assign shifting = (state == S_SH_IR) || (state == S_SH_DR);

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == S_SH_IR) ? ir_lsb : dr_lsb;
      tdo_oe <= shifting;
    end
  end

endmodule

// File: rtl/tap_checker.sv
module tap_checker
  import tap_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir_active,
  input logic            byp_bit,
  input logic            tdo_oe
);

  logic [2:0] ones;

  always_ff @(posedge tck) begin
    if (rst || !tms)  ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  AST_FIVE_HIGH_TLR: assert property (@(posedge tck) disable iff (rst)
    (ones == 3'd5) |-> (state == S_TLR)); // R2

  AST_TLR_LOADS_IDCODE: assert property (@(posedge tck) disable iff (rst)
    (state == S_TLR) |=> (ir_active == OP_IDCODE)); // R1

  AST_IR_HOLDS: assert property (@(posedge tck) disable iff (rst)
    (state != S_UPD_IR && state != S_TLR) |=> $stable(ir_active)); // R10

  AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (rst)
    (state == S_CAP_DR && decode_op(ir_active) == SEL_BYP) |=> !byp_bit); // R7

  AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == S_SH_IR || state == S_SH_DR)); // R9

endmodule

bind tap_ctrl_top tap_checker u_chk (
  .tck(tck), .rst(rst), .tms(tms), .state(state),
  .ir_active(ir_active), .byp_bit(byp_bit), .tdo_oe(tdo_oe)
);

// File: tb/tb_tap_ctrl_top.sv
module tb_tap_ctrl_top;

  localparam int N = 109;
  localparam logic [31:0] EXP_ID = {3'b000, 17'h0B5A3, 11'b00000110100, 1'b1};

  logic tck = 1'b0;
  logic rst, tms, tdi;
  logic [N-1:0] pin_i;
  logic tdo, tdo_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 tck = ~tck;

  tap_ctrl_top dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi),
    .pin_i(pin_i), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic shift_bits(input int n, input logic [127:0] din,
                            output logic [127:0] dout, output bit oe_ok);
    dout = '0; oe_ok = 1;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (tdo_oe !== 1'b1) oe_ok = 0;
      tick(i == n - 1, din[i]);
    end
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din,
                         output logic [127:0] dout);
    bit oe_ok;
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(n, din, dout, oe_ok);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap, output bit oe_ok);
    logic [127:0] d;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(3, {125'b0, op}, d, oe_ok);
    cap = d[2:0];
    tick(1, 0); tick(0, 0);
  endtask

  task automatic t_reset();
    logic [127:0] d;
    chk(tdo_oe === 1'b0, "R1 oe low in reset", tdo_oe, 0);
    rst = 0;
    tick(0, 0);
    chk(tdo_oe === 1'b0, "R9 oe low in idle", tdo_oe, 0);
    scan_dr(32, '0, d);
    chk(d[31:0] === EXP_ID, "R1 R6 idcode after reset", d[31:0], EXP_ID);
  endtask

  task automatic t_ir_capture();
    logic [2:0] c; bit ok;
    load_ir(3'b111, c, ok);
    chk(c === 3'b001, "R4 ir capture pattern", c, 3'b001);
    chk(ok, "R9 oe high in shift-ir", ok, 1);
  endtask

  task automatic t_bypass();
    logic [127:0] d; logic v0; logic [7:0] din;
    din = 8'b1011_0110;
    scan_dr(8, {120'b0, din}, d);
    chk(d[7:0] === {din[6:0], 1'b0}, "R7 bypass one-bit delay", d[7:0], {din[6:0], 1'b0});
    tick(1, 0); tick(0, 0); tick(0, 0);
    tms = 0; tdi = 1; v0 = tdo;
    @(posedge tck); #1;
    chk(tdo === v0, "R9 tdo holds past rising edge", tdo, v0);
    @(negedge tck); #1;
    chk(tdo === 1'b1, "R9 tdo updates on falling edge", tdo, 1);
    tick(1, 0); tick(1, 0); tick(0, 0);
    chk(tdo_oe === 1'b0, "R9 oe low after scan", tdo_oe, 0);
  endtask

  task automatic t_unused(input logic [2:0] op);
    logic [2:0] c; bit ok; logic [127:0] d;
    load_ir(op, c, ok);
    scan_dr(8, 128'hC5, d);
    chk(d[7:0] === 8'h8A, "R5 unused opcode selects bypass", d[7:0], 8'h8A);
  endtask

  task automatic t_sample();
    logic [2:0] c; bit ok; logic [127:0] d, din;
    for (int i = 0; i < N; i++) pin_i[i] = ((i * 7 + 3) % 5) < 2;
    din = '0; din[7:0] = 8'h5B;
    load_ir(3'b100, c, ok);
    scan_dr(N + 8, din, d);
    chk(d[N-1:0] === pin_i, "R8 sample captures pins", d[N-1:0], pin_i);
    chk(d[N+7:N] === 8'h5B, "R8 chain length 109", d[N+7:N], 8'h5B);
  endtask

  task automatic t_extest();
    logic [2:0] c; bit ok; logic [127:0] d;
    for (int i = 0; i < N; i++) pin_i[i] = (i % 3) == 1;
    load_ir(3'b000, c, ok);
    scan_dr(N, '0, d);
    chk(d[N-1:0] === pin_i, "R8 extest captures pins", d[N-1:0], pin_i);
  endtask

  task automatic t_pause();
    logic [2:0] c; bit ok; logic [127:0] a, b;
    load_ir(3'b001, c, ok);
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(16, '0, a, ok);
    tick(0, 0); tick(0, 0);
    chk(tdo_oe === 1'b0, "R3 oe low in pause", tdo_oe, 0);
    tick(1, 0); tick(0, 0);
    shift_bits(16, '0, b, ok);
    tick(1, 0); tick(0, 0);
    chk({b[15:0], a[15:0]} === EXP_ID, "R3 R5 scan resumed after pause",
        {b[15:0], a[15:0]}, EXP_ID);
  endtask

  task automatic t_five_ones();
    logic [2:0] c; bit ok; logic [127:0] d;
    load_ir(3'b111, c, ok);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk(tdo_oe === 1'b0, "R2 oe low after five ones", tdo_oe, 0);
    tick(0, 0);
    scan_dr(32, '0, d);
    chk(d[31:0] === EXP_ID, "R2 R10 idcode after forced reset", d[31:0], EXP_ID);
  endtask

  initial begin
    rst = 1; tms = 1; tdi = 0; pin_i = '0;
    @(negedge tck); #1;
    tick(1, 0); tick(1, 0); tick(1, 0);
    t_reset();
    t_ir_capture();
    t_bypass();
    t_unused(3'b010);
    t_unused(3'b110);
    t_sample();
    t_extest();
    t_pause();
    t_five_ones();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule